// File: doc/BRIEF.md
# SPI Slave Engine with Mode-Fault Detection

This block is the receive/transmit core of a serial peripheral interface slave. An external master drives the serial clock, the active-low select and the master-to-slave data line. The block shifts one byte in and one byte out per transfer, most significant bit first. Both clock polarities and both clock phases are supported. The host processor reaches the block through a small register port. It sets the mode, loads the next byte to send and collects the received byte. Four status flags are visible to the host: transmit buffer empty, receive full, overflow and mode fault. The flags drive two interrupt lines, one for the transmitter and one shared by the receiver and errors.

The master may release the select line while a transfer is still open. The block flags this as a mode fault. The flag is not a reset: the enable bit keeps its value and the shifter keeps its state. Software ends the abandoned transfer by turning the enable bit off and then on again. In phase 0, a transfer opens as soon as the select falls, so any later deselect without the full eight bits is a fault. In phase 1, a transfer opens only on the first clock edge, so a select with no clocking is harmless. The serial inputs pass through a two-stage synchronizer, so the serial clock must run at no more than a quarter of the system clock.

The register port has no back-pressure. Every read or write strobe is taken in the cycle it is presented. Read data is valid in the same cycle as the read strobe. Read side effects take place at the clock edge that ends that cycle.

Top module: `spi_slave_mf`

## Requirements
- R1: After reset, the status register (address 1) reads 0x01, meaning only transmit-empty is set. The control register (address 0) reads 0x00. The MISO enable and both interrupt lines are low.
- R2: Phase-0 mode is selected with control bit 2 = 0, and the idle clock level equals control bit 1. In this mode the master receives the byte written to the data register (address 2), MSB first. The byte shifted in on MOSI is read back from address 2. MISO presents the MSB once select falls, each bit is sampled on the leading edge, and the output shifts on the trailing edge.
- R3: Phase-1 mode is selected with control bit 2 = 1. The data exchange is the same as in R2, but the output shifts on the leading edge and each bit is sampled on the trailing edge. The transfer opens at the first edge and closes at the eighth sampling edge.
- R4: The MISO enable is high only while control bit 0 (enable) is 1 and select is low. Clock edges seen while select is high have no effect on the flags.
- R5: In phase-0 mode, a rise of select before eight bits have been sampled sets status bit 3 (mode fault), even when no clock edge was seen.
- R6: In phase-1 mode, a select/deselect with no clock edge leaves status bit 3 clear. A deselect after clocking has begun, but before the eighth bit, sets it.
- R7: Mode fault is cleared only by a status read while it is set, followed by a control write. The write is rejected, and the flag stays set, while an abandoned transfer is still pending with select high and the block enabled.
- R8: A mode fault leaves the enable bit set and the shifter state intact. No new byte is loaded until enable is turned off and on again, after which transfers work normally.
- R9: Status bit 0 (transmit-empty) is cleared by a write to address 2 and set when the buffered byte moves into the shifter. If no byte was written since, the previous byte is sent again.
- R10: A completed byte sets status bit 1 (receive-full). If receive-full is still set when the next byte completes, status bit 2 (overflow) is set and the data register keeps the older byte. A status read followed by a data read clears both flags.
- R11: The transmit interrupt equals transmit-empty AND control bit 3. The receive/error interrupt is raised by any of three terms. The first is receive-full with control bit 4. The second is overflow with bits 4 and 5. The third is mode fault with bits 4, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the strobe cycle |
| sck | input | 1 | Serial clock from master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for MISO |
| tx_irq | output | 1 | Transmitter interrupt |
| rx_irq | output | 1 | Receiver/error interrupt |

## Verification
The hardest state to reach from the ports is a pending abandoned transfer, because the flag clear must then be refused. Reaching it takes a deselect in the middle of a byte, with the select-low state counted per phase. A status read and control write must then be attempted while the fault condition still holds. The stimulus builds these sequences on purpose: a bare select/deselect in each phase, a three-clock partial byte in phase 1, and a clear first tried while the transfer still hangs and then after the enable is toggled. A seeded random run of full transfers, with random polarity, phase and data bytes, comes before these cases.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

  localparam int unsigned CTRL_W = 7;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2
  } reg_addr_e;

  // MSB-first packing: en is bit 0, mf_en bit 6
  typedef struct packed {
    logic mf_en;
    logic err_ie;
    logic rx_ie;
    logic tx_ie;
    logic cpha;
    logic cpol;
    logic en;
  } ctrl_t;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,   // must be at least 2
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          sck_s,
  input  logic          ss_s,      // synchronized, high = deselected
  input  logic          mosi_s,
  input  logic [DW-1:0] tx_buf,
  output logic          load,      // tx_buf moved into shifter
  output logic          done,      // byte complete this cycle
  output logic [DW-1:0] rx_byte,
  output logic          fault,     // select released mid-transfer
  output logic          active,
  output logic          miso
);

  localparam int unsigned CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sck_q, ss_q;
  logic [DW-1:0] tx_sh;
  logic [DW-2:0] rx_sh;
  logic [CW-1:0] cnt;

  logic sel, sck_edge, lead, trail, samp_e, shft_e;
  logic ss_fall, ss_rise, start0, start1, do_samp, do_shift;

  always_comb begin
    sel      = en & ~ss_s;
    sck_edge = sck_s ^ sck_q;
    lead     = sck_edge & (sck_s != cpol);
    trail    = sck_edge & (sck_s == cpol);
    samp_e   = cpha ? trail : lead;
    shft_e   = cpha ? lead  : trail;
    ss_fall  = ss_q & ~ss_s;
    ss_rise  = ~ss_q & ss_s;
    start0   = en & ~cpha & ss_fall & ~active;
    start1   = sel & cpha & lead & ~active;
    load     = start0 | start1;
    fault    = en & ss_rise & active;
    do_samp  = sel & active & samp_e;
    do_shift = sel & active & shft_e;
    done     = do_samp & (cnt == LAST);
    rx_byte  = {rx_sh, mosi_s};
    miso     = tx_sh[DW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      ss_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      ss_q  <= ss_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (!en) begin
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      if (load) begin
        tx_sh  <= tx_buf;
        active <= 1'b1;
        cnt    <= '0;
      end else if (do_shift) begin
        tx_sh <= {tx_sh[DW-2:0], 1'b0};
      end
      if (do_samp) begin
        rx_sh <= rx_byte[DW-2:0];
        if (done) begin
          active <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_slave_regs.sv
module spi_slave_regs
  import spi_slave_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          load,
  input  logic          done,
  input  logic [DW-1:0] rx_byte,
  input  logic          fault,
  input  logic          fault_cond,
  output ctrl_t         ctrl,
  output logic [DW-1:0] tx_buf,
  output logic [DW-1:0] rx_data,
  output logic          txe,
  output logic          rxf,
  output logic          ovr,
  output logic          modf,
  output logic          tx_irq,
  output logic          rx_irq
);

  logic stat_rd, data_rd, ctrl_wr, data_wr;
  logic rx_arm, mf_arm, rx_clr, mf_clr;
  logic wdata_unused;

  assign wdata_unused = ^bus_wdata[DW-1:CTRL_W];

  always_comb begin
    stat_rd = bus_rd & (bus_addr == A_STAT);
    data_rd = bus_rd & (bus_addr == A_DATA);
    ctrl_wr = bus_wr & (bus_addr == A_CTRL);
    data_wr = bus_wr & (bus_addr == A_DATA);
    rx_clr  = data_rd & rx_arm;
    mf_clr  = ctrl_wr & mf_arm & ~fault_cond;
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = DW'(ctrl);
      A_STAT:  bus_rdata = DW'({modf, ovr, rxf, txe});
      A_DATA:  bus_rdata = rx_data;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      tx_buf  <= '0;
      rx_data <= '0;
      txe     <= 1'b1;
      rxf     <= 1'b0;
      ovr     <= 1'b0;
      modf    <= 1'b0;
      rx_arm  <= 1'b0;
      mf_arm  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);

      if (data_wr) begin
        tx_buf <= bus_wdata;
        txe    <= 1'b0;
      end else if (load) begin
        txe <= 1'b1;
      end

      if (data_rd)                  rx_arm <= 1'b0;
      else if (stat_rd & (rxf|ovr)) rx_arm <= 1'b1;

      if (done & (~rxf | rx_clr)) rx_data <= rx_byte;
      if (done)        rxf <= 1'b1;
      else if (rx_clr) rxf <= 1'b0;
      if (done & rxf & ~rx_clr) ovr <= 1'b1;
      else if (rx_clr)          ovr <= 1'b0;

      if (ctrl_wr)              mf_arm <= 1'b0;
      else if (stat_rd & modf)  mf_arm <= 1'b1;

      if (fault)       modf <= 1'b1;
      else if (mf_clr) modf <= 1'b0;
    end
  end

  always_comb begin
    tx_irq = txe & ctrl.tx_ie;
    rx_irq = ctrl.rx_ie & (rxf | (ovr & ctrl.err_ie)
                               | (modf & ctrl.err_ie & ctrl.mf_en));
  end

endmodule

// File: rtl/spi_slave_mf.sv
module spi_slave_mf
  import spi_slave_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sck,
  input  logic          ss_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic          tx_irq,
  output logic          rx_irq
);

  logic          sck_s, ss_s, mosi_s;
  ctrl_t         ctrl_q;
  logic          en, rx_ie;
  logic [DW-1:0] tx_buf, rx_byte, rx_data_q;
  logic          load, done, fault, active;
  logic          txe, rxf, ovr, modf;

  spi_sync #(.W(3), .STAGES(2), .RST(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sck, ss_n, mosi}),
    .q     ({sck_s, ss_s, mosi_s})
  );

  assign en    = ctrl_q.en;
  assign rx_ie = ctrl_q.rx_ie;

  spi_shift_eng #(.DW(DW)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .cpol    (ctrl_q.cpol),
    .cpha    (ctrl_q.cpha),
    .sck_s   (sck_s),
    .ss_s    (ss_s),
    .mosi_s  (mosi_s),
    .tx_buf  (tx_buf),
    .load    (load),
    .done    (done),
    .rx_byte (rx_byte),
    .fault   (fault),
    .active  (active),
    .miso    (miso)
  );

  spi_slave_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .load       (load),
    .done       (done),
    .rx_byte    (rx_byte),
    .fault      (fault),
    .fault_cond (en & active & ss_s),
    .ctrl       (ctrl_q),
    .tx_buf     (tx_buf),
    .rx_data    (rx_data_q),
    .txe        (txe),
    .rxf        (rxf),
    .ovr        (ovr),
    .modf       (modf),
    .tx_irq     (tx_irq),
    .rx_irq     (rx_irq)
  );

  assign miso_oe = en & ~ss_s;

endmodule

// File: rtl/spi_slave_mf_chk.sv
module spi_slave_mf_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic          en,
  input logic          rx_ie,
  input logic          txe,
  input logic          modf,
  input logic          ovr,
  input logic [DW-1:0] rx_data,
  input logic          active,
  input logic          miso_oe,
  input logic          tx_irq,
  input logic          rx_irq
);

  AST_OE_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !miso_oe); // R4

  AST_TXE_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2) |=> !txe); // R9

  AST_MODF_HELD_WITHOUT_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (modf && !(bus_wr && bus_addr == 2'd0)) |=> modf); // R7

  AST_MODF_ONLY_FROM_OPEN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> $past(active)); // R6

  AST_OVR_KEEPS_OLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $stable(rx_data)); // R10

  AST_RX_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ie |-> !rx_irq); // R11

  AST_TX_IRQ_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> txe); // R11

endmodule

bind spi_slave_mf spi_slave_mf_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .en       (en),
  .rx_ie    (rx_ie),
  .txe      (txe),
  .modf     (modf),
  .ovr      (ovr),
  .rx_data  (rx_data_q),
  .active   (active),
  .miso_oe  (miso_oe),
  .tx_irq   (tx_irq),
  .rx_irq   (rx_irq)
);

// File: tb/spi_slave_mf_tb.sv
module spi_slave_mf_tb;

  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic       miso, miso_oe, tx_irq, rx_irq;

  int vecs = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spi_slave_mf u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso), .miso_oe(miso_oe),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  function automatic logic [7:0] cfg(bit en, bit pol, bit ph, bit tie,
                                     bit rie, bit eie, bit mie);
    return {1'b0, mie, eie, rie, tie, ph, pol, en};
  endfunction

  function automatic logic [7:0] stat_exp(bit te, bit rf, bit ov, bit mf);
    return {4'b0, mf, ov, rf, te};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // master model; nbits < 8 leaves a partial transfer
  task automatic xfer(bit pol, bit ph, logic [7:0] mo, int nbits, bit rel,
                      output logic [7:0] mi);
    mi = 8'h00;
    sck = pol;
    if (!ph) begin
      mosi = mo[7];
      tick(2); ss_n = 1'b0; tick(HALF);
      for (int i = 0; i < nbits; i++) begin
        mi[7-i] = miso;
        sck = ~pol; tick(HALF);
        sck = pol;
        if (i < 7) mosi = mo[6-i];
        tick(HALF);
      end
    end else begin
      tick(2); ss_n = 1'b0; tick(HALF);
      for (int i = 0; i < nbits; i++) begin
        sck = ~pol; mosi = mo[7-i]; tick(HALF);
        mi[7-i] = miso;
        sck = pol; tick(HALF);
      end
    end
    if (rel) ss_n = 1'b1;
    tick(4);
  endtask

  initial begin
    logic [7:0] st, d, mi, tx, mo;
    bit pol, ph;
    void'($urandom(32'h1357_2468));
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    rd(2'd1, st); chk("R1 status", st, stat_exp(1, 0, 0, 0));
    rd(2'd0, d);  chk("R1 ctrl", d, 8'h00);
    chk("R1 oe", miso_oe, 0);
    chk("R1 irqs", {tx_irq, rx_irq}, 0);

    // random full transfers, R2 (phase 0) and R3 (phase 1)
    for (int it = 0; it < 24; it++) begin
      pol = 1'($urandom % 2); ph = 1'($urandom % 2);
      tx  = 8'($urandom);     mo = 8'($urandom);
      sck = pol; tick(4);
      wr(2'd0, cfg(1, pol, ph, 0, 0, 0, 0));
      wr(2'd2, tx);
      xfer(pol, ph, mo, 8, 1, mi);
      chk(ph ? "R3 miso byte" : "R2 miso byte", mi, tx);
      rd(2'd1, st); chk("R10 rxf set, no fault", st, stat_exp(1, 1, 0, 0));
      rd(2'd2, d);  chk(ph ? "R3 mosi byte" : "R2 mosi byte", d, mo);
      rd(2'd1, st); chk("R10 rxf cleared", st, stat_exp(1, 0, 0, 0));
    end

    // R4 clocks while deselected, output enable
    sck = 1'b0; tick(4);
    wr(2'd0, cfg(1, 0, 1, 0, 0, 0, 0));
    for (int k = 0; k < 8; k++) begin
      sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
    end
    chk("R4 oe off deselected", miso_oe, 0);
    rd(2'd1, st); chk("R4 clocks ignored", st, stat_exp(1, 0, 0, 0));
    ss_n = 1'b0; tick(4);
    chk("R4 oe on selected", miso_oe, 1);
    wr(2'd0, cfg(0, 0, 1, 0, 0, 0, 0)); tick(1);
    chk("R4 oe off disabled", miso_oe, 0);
    ss_n = 1'b1; tick(4);
    wr(2'd0, cfg(1, 0, 1, 0, 0, 0, 0));

    // R9 transmit empty and resend
    wr(2'd2, 8'hA5);
    rd(2'd1, st); chk("R9 write clears txe", st, stat_exp(0, 0, 0, 0));
    xfer(0, 1, 8'h11, 8, 1, mi); chk("R9 first send", mi, 8'hA5);
    rd(2'd1, st); chk("R9 txe after load", st, stat_exp(1, 1, 0, 0));
    rd(2'd2, d);
    xfer(0, 1, 8'h3C, 8, 1, mi); chk("R9 resend old byte", mi, 8'hA5);

    // R10 overflow keeps older byte
    xfer(0, 1, 8'hC3, 8, 1, mi);
    rd(2'd1, st); chk("R10 overflow", st, stat_exp(1, 1, 1, 0));
    rd(2'd2, d);  chk("R10 old byte kept", d, 8'h3C);
    rd(2'd1, st); chk("R10 cleared", st, stat_exp(1, 0, 0, 0));

    // R11 interrupt gating
    wr(2'd2, 8'h0F);
    wr(2'd0, cfg(1, 0, 1, 1, 0, 0, 0)); tick(1);
    chk("R11 tx irq with txe=0", tx_irq, 0);
    xfer(0, 1, 8'h77, 8, 1, mi);
    chk("R11 tx irq with txe=1", tx_irq, 1);
    chk("R11 rx irq masked", rx_irq, 0);
    wr(2'd0, cfg(1, 0, 1, 0, 1, 0, 0)); tick(1);
    chk("R11 rx irq on rxf", rx_irq, 1);
    rd(2'd1, st); rd(2'd2, d);

    // R5 phase-0 fault without clocks
    sck = 1'b0; tick(4);
    wr(2'd0, cfg(1, 0, 0, 0, 1, 1, 0));
    ss_n = 1'b0; tick(8); ss_n = 1'b1; tick(6);
    rd(2'd1, st); chk("R5 phase0 fault", st, stat_exp(1, 0, 0, 1));
    chk("R11 modf irq needs mf enable", rx_irq, 0);
    wr(2'd0, cfg(1, 0, 0, 0, 1, 1, 1)); tick(1);
    chk("R11 modf irq", rx_irq, 1);
    rd(2'd0, d); chk("R8 enable kept", d, cfg(1, 0, 0, 0, 1, 1, 1));

    // R8 shifter not reset: no reload on reselect
    wr(2'd2, 8'h5A);
    ss_n = 1'b0; tick(8);
    rd(2'd1, st); chk("R8 no reload", st, stat_exp(0, 0, 0, 1));
    ss_n = 1'b1; tick(6);

    // R7 clear sequence
    wr(2'd0, cfg(1, 0, 0, 0, 0, 0, 0));
    rd(2'd1, st); chk("R7 first status", st, stat_exp(0, 0, 0, 1));
    wr(2'd0, cfg(1, 0, 0, 0, 0, 0, 0));
    rd(2'd1, st); chk("R7 rejected while pending", st, stat_exp(0, 0, 0, 1));
    wr(2'd0, cfg(0, 0, 0, 0, 0, 0, 0));
    wr(2'd0, cfg(0, 0, 0, 0, 0, 0, 0));
    rd(2'd1, st); chk("R7 needs status read", st, stat_exp(0, 0, 0, 1));
    wr(2'd0, cfg(1, 0, 0, 0, 0, 0, 0));
    rd(2'd1, st); chk("R7 cleared", st, stat_exp(0, 0, 0, 0));
    xfer(0, 0, 8'h96, 8, 1, mi); chk("R8 works after toggle", mi, 8'h5A);
    rd(2'd1, st); chk("R8 status after toggle", st, stat_exp(1, 1, 0, 0));
    rd(2'd2, d);  chk("R8 rx after toggle", d, 8'h96);

    // R6 phase-1 fault rules
    sck = 1'b1; tick(4);
    wr(2'd0, cfg(1, 1, 1, 0, 0, 0, 0));
    ss_n = 1'b0; tick(8); ss_n = 1'b1; tick(6);
    rd(2'd1, st); chk("R6 idle select no fault", st, stat_exp(1, 0, 0, 0));
    xfer(1, 1, 8'hF0, 3, 0, mi);
    ss_n = 1'b1; tick(6);
    rd(2'd1, st); chk("R6 fault after clocks", st, stat_exp(1, 0, 0, 1));
    wr(2'd0, cfg(0, 1, 1, 0, 0, 0, 0));
    rd(2'd1, st);
    wr(2'd0, cfg(1, 1, 1, 0, 0, 0, 0));
    rd(2'd1, st); chk("R7 cleared after toggle", st, stat_exp(1, 0, 0, 0));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog R1: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule